// File: doc/BRIEF.md
# Three-Phase Gate Command Logic

This block turns six active-high PWM requests into six gate commands for a three-phase half-bridge inverter. Each phase takes one high-side request and one low-side request. Every request first passes through a digital deglitch filter whose length is a parameter counted in clock cycles. A per-phase lockout then turns both switches of a phase off whenever both of its requests are high. This prevents shoot-through and does not favour either side.

A global enable input has its own deglitch filter, which is normally shorter than the PWM filter. A current-trip fault input forces every gate command off. Both forcing terms are applied after the lockout. All six commands come from registers. Dead time, level shifting and supply monitoring are handled elsewhere. The block is placed between a PWM generator and the analog gate drivers.

Top module: `tri_gate_cmd`

## Requirements
- R1: For a phase whose filtered high request is 1 and filtered low request is 0, with drive allowed, `ho` bit of that phase is 1 and `lo` bit is 0. Bit i of `hin`, `lin`, `ho`, `lo` all belong to phase i.
- R2: For a phase whose filtered low request is 1 and filtered high request is 0, with drive allowed, `lo` is 1 and `ho` is 0 for that phase.
- R3: When both filtered requests of a phase are equal (both 0 or both 1), both commands of that phase are 0. No ordering of input edges ever gives `ho[i]` and `lo[i]` both 1 in the same cycle.
- R4: A low level on `en` is counted by its own filter of `EN_FILT_CYC` cycles. A low pulse on `en` of fewer than `EN_FILT_CYC` sampled cycles has no effect. A low level held for `EN_FILT_CYC` samples makes all outputs 0 on the next edge, which is edge number `EN_FILT_CYC`+1 counting the first edge that samples the low level. Raising `en` again restores drive with the same latency.
- R5: `fault_active` is not filtered. When it is sampled high at an edge, all six outputs are 0 after that edge, and they stay 0 while it stays high. The outputs resume one edge after it is sampled low.
- R6: A PWM request that changes is accepted only after `PWM_FILT_CYC` consecutive sampled cycles at the new level. A pulse of fewer cycles is rejected. An accepted change reaches the output on edge `PWM_FILT_CYC`+1, counting the first edge that samples the new level.
- R7: While `rst_n` is low, all outputs are 0. Every filtered signal, including the enable, starts at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hin | input | PHASES | High-side PWM request per phase, active high |
| lin | input | PHASES | Low-side PWM request per phase, active high |
| en | input | 1 | Global drive enable, active high, filtered |
| fault_active | input | 1 | Current-trip fault, active high, unfiltered |
| ho | output | PHASES | High-side gate command per phase |
| lo | output | PHASES | Low-side gate command per phase |

## Verification
A filter counter left in the wrong state shows up at the ports as an edge one or more cycles early or late. A counter that fails to clear shows up as a glitch that leaks through. The bench therefore samples exactly one cycle before and one cycle after each expected change. A broken lockout or broken forcing path shows up as overlapping or stray commands within one cycle of the input pattern that provokes it. The bench watches every cycle through skewed request edges and through enable pulses that are too short to pass the filter.

// File: rtl/gate_cmd_pkg.sv
package gate_cmd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic allowDrive;  // filtered enable level
    logic tripNow;     // raw fault level, acts on the next edge
  } ctrlStrobe_t;
endpackage

// File: rtl/gc_deglitch.sv
module gc_deglitch #(
  parameter int FILT_CYC = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] runCnt;
  logic          filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      filtQ  <= 1'b0;
    end else if (rawIn == filtQ) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      filtQ  <= rawIn;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign filtOut = filtQ;

  // R6 / R4: a filtered level only ever moves to the level the raw input had
  p_filt_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtQ) |-> (filtQ == $past(rawIn)));

  // R6: an input matching the filtered level never moves it
  p_filt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rawIn == filtQ) |=> $stable(filtQ));
endmodule

// File: rtl/gc_ctrl.sv
module gc_ctrl
  import gate_cmd_pkg::*;
#(
  parameter int EN_FILT_CYC = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enRaw,
  input  logic        faultRaw,
  output ctrlStrobe_t strobe
);
  logic enFilt;

  gc_deglitch #(.FILT_CYC(EN_FILT_CYC)) enFilter_i (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (enRaw),
    .filtOut(enFilt)
  );

  always_comb begin
    strobe.allowDrive = enFilt;
    strobe.tripNow    = faultRaw;
  end

  // R4: drive permission drops only after the raw enable was low
  p_en_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.allowDrive) |-> !$past(enRaw));
endmodule

// File: rtl/gc_datapath.sv
module gc_datapath
  import gate_cmd_pkg::*;
#(
  parameter int PHASES       = 3,
  parameter int PWM_FILT_CYC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] hinRaw,
  input  logic [PHASES-1:0] linRaw,
  input  ctrlStrobe_t       strobe,
  output logic [PHASES-1:0] hoCmd,
  output logic [PHASES-1:0] loCmd
);
  logic [PHASES-1:0] hiFilt, loFilt;
  logic [PHASES-1:0] hiSel, loSel;
  logic [PHASES-1:0] hoQ, loQ;
  logic              gateOk;

  assign gateOk = strobe.allowDrive & ~strobe.tripNow;

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
    gc_deglitch #(.FILT_CYC(PWM_FILT_CYC)) hiFilter_i (
      .clk(clk), .rstN(rstN), .rawIn(hinRaw[ph]), .filtOut(hiFilt[ph]));
    gc_deglitch #(.FILT_CYC(PWM_FILT_CYC)) loFilter_i (
      .clk(clk), .rstN(rstN), .rawIn(linRaw[ph]), .filtOut(loFilt[ph]));

    // symmetric lockout, then forcing
    always_comb begin
      hiSel[ph] = hiFilt[ph] & ~loFilt[ph] & gateOk;
      loSel[ph] = loFilt[ph] & ~hiFilt[ph] & gateOk;
    end

    // R1: a lone high request drives the high side only
    p_hi_only_r1: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.allowDrive && !strobe.tripNow && hiFilt[ph] && !loFilt[ph])
        |=> (hoQ[ph] && !loQ[ph]));

    // R2: a lone low request drives the low side only
    p_lo_only_r2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.allowDrive && !strobe.tripNow && loFilt[ph] && !hiFilt[ph])
        |=> (loQ[ph] && !hoQ[ph]));

    // R3: both sides of one phase never commanded together
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
      !(hoQ[ph] && loQ[ph]));

    // R3: equal requests give both sides off
    p_equal_off_r3: assert property (@(posedge clk) disable iff (!rstN)
      (hiFilt[ph] == loFilt[ph]) |=> (!hoQ[ph] && !loQ[ph]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hoQ <= '0;
      loQ <= '0;
    end else begin
      hoQ <= hiSel;
      loQ <= loSel;
    end
  end

  assign hoCmd = hoQ;
  assign loCmd = loQ;

  // R5: a fault sampled at an edge blanks every command after it
  p_fault_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tripNow |=> (hoQ == '0 && loQ == '0));

  // R4: without drive permission every command is off next cycle
  p_en_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.allowDrive |=> (hoQ == '0 && loQ == '0));
endmodule

// File: rtl/tri_gate_cmd.sv
module tri_gate_cmd
  import gate_cmd_pkg::*;
#(
  parameter int PHASES       = 3,
  parameter int PWM_FILT_CYC = 32,
  parameter int EN_FILT_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hin,
  input  logic [PHASES-1:0] lin,
  input  logic              en,
  input  logic              fault_active,
  output logic [PHASES-1:0] ho,
  output logic [PHASES-1:0] lo
);
  ctrlStrobe_t ctrlStrobe;

  gc_ctrl #(.EN_FILT_CYC(EN_FILT_CYC)) ctrl_i (
    .clk     (clk),
    .rstN    (rst_n),
    .enRaw   (en),
    .faultRaw(fault_active),
    .strobe  (ctrlStrobe)
  );

  gc_datapath #(.PHASES(PHASES), .PWM_FILT_CYC(PWM_FILT_CYC)) dp_i (
    .clk   (clk),
    .rstN  (rst_n),
    .hinRaw(hin),
    .linRaw(lin),
    .strobe(ctrlStrobe),
    .hoCmd (ho),
    .loCmd (lo)
  );

  // R7: outputs held off during reset
  always_comb begin
    if (!rst_n) p_reset_off_r7: assert (ho == '0 && lo == '0);
  end
endmodule

// File: tb/tri_gate_cmd_tb_top.sv
module tri_gate_cmd_tb_top;
  localparam int PWM = 32;
  localparam int ENF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hin = '0, lin = '0;
  logic en = 1'b0, fault_active = 1'b0;
  logic [2:0] ho, lo;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tri_gate_cmd #(.PHASES(3), .PWM_FILT_CYC(PWM), .EN_FILT_CYC(ENF)) dut_i (
    .clk(clk), .rst_n(rst_n), .hin(hin), .lin(lin), .en(en),
    .fault_active(fault_active), .ho(ho), .lo(lo));

  // {hin, lin, expected ho, expected lo}
  localparam logic [11:0] VEC [8] = '{
    {3'b001, 3'b000, 3'b001, 3'b000},  // R1
    {3'b000, 3'b010, 3'b000, 3'b010},  // R2
    {3'b111, 3'b000, 3'b111, 3'b000},  // R1
    {3'b000, 3'b111, 3'b000, 3'b111},  // R2
    {3'b101, 3'b011, 3'b100, 3'b010},  // R3 mixed
    {3'b111, 3'b111, 3'b000, 3'b000},  // R3 both high
    {3'b010, 3'b101, 3'b010, 3'b101},  // R1 and R2
    {3'b000, 3'b000, 3'b000, 3'b000}   // R3 both low
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual {ho,lo}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    tick(150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit bad;
    tick(3);
    check("R7 outputs off in reset", {ho, lo}, 6'b0);
    rst_n = 1'b1;
    en = 1'b1;
    hin = 3'b001;
    tick(1);
    check("R7 outputs off right after reset", {ho, lo}, 6'b0);
    hin = 3'b000;
    tick(PWM + 4);

    // vector walk (R1 R2 R3)
    for (int v = 0; v < 8; v++) begin
      hin = VEC[v][11:9];
      lin = VEC[v][8:6];
      tick(PWM + 3);
      check($sformatf("R1/R2/R3 vector %0d", v), {ho, lo}, VEC[v][5:0]);
    end

    // R6: glitch one cycle short of the filter is rejected
    bad = 1'b0;
    hin = 3'b001;
    for (int c = 0; c < PWM - 1; c++) begin tick(1); if (ho != 0) bad = 1'b1; end
    hin = 3'b000;
    for (int c = 0; c < PWM + 3; c++) begin tick(1); if (ho != 0) bad = 1'b1; end
    check("R6 short pulse rejected", {5'b0, bad}, 6'b0);

    // R6: accepted edge appears on edge PWM+1
    hin = 3'b001;
    tick(PWM);
    check("R6 one cycle before accept", {ho, lo}, 6'b0);
    tick(1);
    check("R6 accepted edge", {ho, lo}, 6'b001_000);

    // R5: fault blanks next edge, resumes next edge after release
    fault_active = 1'b1;
    tick(1);
    check("R5 fault blanks", {ho, lo}, 6'b0);
    tick(3);
    check("R5 fault held", {ho, lo}, 6'b0);
    fault_active = 1'b0;
    tick(1);
    check("R5 resume after fault", {ho, lo}, 6'b001_000);

    // R4: enable glitch too short is ignored
    bad = 1'b0;
    en = 1'b0;
    for (int c = 0; c < ENF - 1; c++) begin tick(1); if (ho != 3'b001) bad = 1'b1; end
    en = 1'b1;
    for (int c = 0; c < ENF + 3; c++) begin tick(1); if (ho != 3'b001) bad = 1'b1; end
    check("R4 short enable drop ignored", {5'b0, bad}, 6'b0);

    // R4: held drop takes effect on edge ENF+1
    en = 1'b0;
    tick(ENF);
    check("R4 before enable drop", {ho, lo}, 6'b001_000);
    tick(1);
    check("R4 enable drop", {ho, lo}, 6'b0);
    en = 1'b1;
    tick(ENF);
    check("R4 before re-enable", {ho, lo}, 6'b0);
    tick(1);
    check("R4 re-enable", {ho, lo}, 6'b001_000);

    // R3: skewed overlap never gives both sides of a phase
    bad = 1'b0;
    lin = 3'b001;
    for (int c = 0; c < PWM + 4; c++) begin tick(1); if ((ho & lo) != 0) bad = 1'b1; end
    check("R3 overlap both off", {ho, lo}, 6'b0);
    hin = 3'b000;
    for (int c = 0; c < PWM + 4; c++) begin tick(1); if ((ho & lo) != 0) bad = 1'b1; end
    check("R3 no overlap during handover", {5'b0, bad}, 6'b0);
    check("R2 low side after handover", {ho, lo}, 6'b000_001);

    finish_run();
  end
endmodule